// File: doc/BRIEF.md
# Multi-Sector Erase Collection Window

This block sits behind the command decoder of a parallel flash controller. It gathers the set of sectors that one erase will clear. The first sector-erase write opens an accept window that is counted in clock cycles. Each further sector-erase write that arrives while the window is open adds its sector to a 19-bit select mask and restarts the count. When the count runs out, the block raises a one-cycle start pulse for the erase engine. It then holds the mask steady until the engine reports completion.

Two commands can cut the window short. A suspend closes the window at once and parks the block in a suspended state with the mask kept. Any other command, including a resume, cancels the whole erase and clears the mask. The mapping of addresses to sector numbers for either boot layout happens upstream, so this block receives a sector index directly. The window flag is meant to drive the status bit that tells software whether more sectors may still be added.

Top module: `sew_accum`

## Requirements
- R1: After reset, a sector-erase write with index 0..18 while idle causes the next cycle to show `window_open`=1 and `sel_mask` with only bit `sec_idx` set.
- R2: If no further write arrives, `window_open` stays high for exactly WIN_CYC cycles after the cycle of the last accepted write. It then drops, `start_pulse` is high for one cycle at the same time, and the mask is kept.
- R3: A valid sector-erase write during the window ORs its bit into the mask and restarts the full WIN_CYC count. This includes a write in the window's final cycle.
- R4: A write for a sector already in the mask restarts the count and leaves the mask unchanged.
- R5: While the window is open, `other_cmd_wr` or `resume_wr` aborts the erase. The next cycle shows `abort_pulse`=1 for one cycle, `sel_mask`=0 and `window_open`=0. This takes priority over a suspend or a sector write in the same cycle.
- R6: A suspend during the window closes it on the next cycle, sets `erase_suspended`, keeps the mask and gives no start pulse. A suspend beats a sector write in the same cycle.
- R7: While suspended, `resume_wr` returns the block to busy. If the erase was never started, `start_pulse` is high for one cycle along with the return; otherwise no pulse is given.
- R8: While busy, sector-erase writes and other commands are ignored and the mask is held. `suspend_wr` moves the block to the suspended state.
- R9: `erase_done` while busy returns the block to idle with the mask cleared. It beats a same-cycle suspend and is ignored in every other state.
- R10: A sector-erase write with an index of 19 or above is ignored. It neither opens nor restarts the window.
- R11: All 19 sectors can be selected at once, giving a mask of 0x7FFFF.
- R12: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_erase_wr | input | 1 | Sector-erase command pulse |
| sec_idx | input | 5 | Sector number carried with the sector-erase command |
| suspend_wr | input | 1 | Erase-suspend command pulse |
| resume_wr | input | 1 | Erase-resume command pulse |
| other_cmd_wr | input | 1 | Pulse for any other decoded command |
| erase_done | input | 1 | Completion pulse from the erase engine |
| sel_mask | output | 19 | Selected sectors, bit n = sector n |
| window_open | output | 1 | Accept window running |
| erase_suspended | output | 1 | Erase suspended |
| abort_pulse | output | 1 | One-cycle pulse: erase cancelled |
| start_pulse | output | 1 | One-cycle pulse: erase engine may begin |

## Verification
The delicate coincidence is a sector write landing in the same cycle the window count reaches zero. The write must win, so the mask grows, the count restarts and no start pulse appears. The bench provokes this directly by writing on the final window cycle. It also provokes it by chance through random write density with a short window. A cycle model in the bench decides each outcome. The same model also judges abort, suspend or erase_done colliding with sector writes, and every output is compared on every cycle.

// File: rtl/sew_pkg.sv
package sew_pkg;
  localparam int NUM_SECT = 19;
  localparam int IDX_W    = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_BUSY = 2'd2,
    ST_SUSP = 2'd3
  } sew_state_e;

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return (int'(idx) < NUM_SECT);
  endfunction

  function automatic logic [NUM_SECT-1:0] sect_bit(input logic [IDX_W-1:0] idx);
    logic [NUM_SECT-1:0] b;
    b = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (int'(idx) == i) b[i] = 1'b1;
    end
    return b;
  endfunction
endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
  parameter int WIN_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(WIN_CYC + 1);
  localparam logic [TW-1:0] LOADV = TW'(WIN_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= LOADV;
    else if (run && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sew_mask.sv
module sew_mask
  import sew_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 add,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_SECT-1:0]  mask
);
  logic [NUM_SECT-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (clr)  mask_q <= '0;
    else if (add)  mask_q <= mask_q | sect_bit(idx);
  end

  assign mask = mask_q;
endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       suspend_wr,
  input  logic       resume_wr,
  input  logic       other_cmd_wr,
  input  logic       erase_done,
  input  logic       expired,
  output logic       timer_load,
  output logic       timer_run,
  output logic       mask_add,
  output logic       mask_clr,
  output sew_state_e state,
  output logic       abort_pulse,
  output logic       start_pulse
);
  sew_state_e st_q, st_d;
  logic started_q, started_d;
  logic abort_ev, start_ev;
  logic cancel;

  assign cancel = other_cmd_wr | resume_wr;

  always_comb begin
    st_d       = st_q;
    started_d  = started_q;
    timer_load = 1'b0;
    mask_add   = 1'b0;
    mask_clr   = 1'b0;
    abort_ev   = 1'b0;
    start_ev   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d       = ST_WIN;
          timer_load = 1'b1;
          mask_add   = 1'b1;
        end
      end
      ST_WIN: begin
        if (cancel) begin
          st_d      = ST_IDLE;
          mask_clr  = 1'b1;
          abort_ev  = 1'b1;
          started_d = 1'b0;
        end else if (suspend_wr) begin
          st_d = ST_SUSP;
        end else if (accept) begin
          timer_load = 1'b1;
          mask_add   = 1'b1;
        end else if (expired) begin
          st_d      = ST_BUSY;
          start_ev  = 1'b1;
          started_d = 1'b1;
        end
      end
      ST_BUSY: begin
        if (erase_done) begin
          st_d      = ST_IDLE;
          mask_clr  = 1'b1;
          started_d = 1'b0;
        end else if (suspend_wr) begin
          st_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (resume_wr) begin
          st_d = ST_BUSY;
          if (!started_q) begin
            start_ev  = 1'b1;
            started_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      started_q   <= 1'b0;
      abort_pulse <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      st_q        <= st_d;
      started_q   <= started_d;
      abort_pulse <= abort_ev;
      start_pulse <= start_ev;
    end
  end

  assign timer_run = (st_q == ST_WIN);
  assign state     = st_q;
endmodule

// File: rtl/sew_accum.sv
module sew_accum
  import sew_pkg::*;
#(
  parameter int WIN_CYC = 6250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_erase_wr,
  input  logic [4:0]          sec_idx,
  input  logic                suspend_wr,
  input  logic                resume_wr,
  input  logic                other_cmd_wr,
  input  logic                erase_done,
  output logic [18:0]         sel_mask,
  output logic                window_open,
  output logic                erase_suspended,
  output logic                abort_pulse,
  output logic                start_pulse
);
  logic       accept;
  logic       timer_load, timer_run, timer_expired;
  logic       mask_add, mask_clr;
  sew_state_e state;

  assign accept = sec_erase_wr & idx_ok(sec_idx);

  sew_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .run     (timer_run),
    .expired (timer_expired)
  );

  sew_mask u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mask_clr),
    .add   (mask_add),
    .idx   (sec_idx),
    .mask  (sel_mask)
  );

  sew_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .suspend_wr   (suspend_wr),
    .resume_wr    (resume_wr),
    .other_cmd_wr (other_cmd_wr),
    .erase_done   (erase_done),
    .expired      (timer_expired),
    .timer_load   (timer_load),
    .timer_run    (timer_run),
    .mask_add     (mask_add),
    .mask_clr     (mask_clr),
    .state        (state),
    .abort_pulse  (abort_pulse),
    .start_pulse  (start_pulse)
  );

  assign window_open     = (state == ST_WIN);
  assign erase_suspended = (state == ST_SUSP);
endmodule

// File: rtl/sew_accum_chk.sv
module sew_accum_chk #(
  parameter int WIN_CYC = 6250
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_erase_wr,
  input logic [4:0]  sec_idx,
  input logic        suspend_wr,
  input logic        resume_wr,
  input logic        other_cmd_wr,
  input logic        erase_done,
  input logic [18:0] sel_mask,
  input logic        window_open,
  input logic        erase_suspended,
  input logic        abort_pulse,
  input logic        start_pulse,
  input logic        timer_expired
);
  logic ok_wr;
  int   since_wr;

  assign ok_wr = sec_erase_wr && (sec_idx < 5'd19);

  always_ff @(posedge clk) begin
    if (!rst_n || !window_open || ok_wr) since_wr <= 0;
    else                                 since_wr <= since_wr + 1;
  end

  // R2: window never outlives its length after the last accepted write
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> since_wr < WIN_CYC);

  // R2 / R3: quiet expiry gives a start pulse
  p_expiry_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && timer_expired && !sec_erase_wr && !suspend_wr &&
     !other_cmd_wr && !resume_wr) |=> (start_pulse && !window_open));

  // R3: mask only grows while the window is open
  p_mask_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && ok_wr && !other_cmd_wr && !resume_wr && !suspend_wr)
      |=> ((sel_mask & $past(sel_mask)) == $past(sel_mask)) && window_open);

  // R5: abort leaves nothing behind
  p_abort_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (sel_mask == '0) && !window_open && !erase_suspended);

  // R6: window and suspended are exclusive
  p_state_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({window_open, erase_suspended}));

  // R8: mask held once the window has closed on a live erase
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!window_open && sel_mask != '0) |=> (sel_mask == $past(sel_mask)) || (sel_mask == '0));

  // R9: erase_done ignored while suspended
  p_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_suspended && erase_done && !resume_wr) |=> erase_suspended);

  // R12: pulses never overlap
  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && start_pulse));
endmodule

bind sew_accum sew_accum_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sec_erase_wr    (sec_erase_wr),
  .sec_idx         (sec_idx),
  .suspend_wr      (suspend_wr),
  .resume_wr       (resume_wr),
  .other_cmd_wr    (other_cmd_wr),
  .erase_done      (erase_done),
  .sel_mask        (sel_mask),
  .window_open     (window_open),
  .erase_suspended (erase_suspended),
  .abort_pulse     (abort_pulse),
  .start_pulse     (start_pulse),
  .timer_expired   (timer_expired)
);

// File: tb/sew_accum_tb.sv
module sew_accum_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se = 1'b0, su = 1'b0, re = 1'b0, ot = 1'b0, dn = 1'b0;
  logic [4:0] idx = '0;
  logic [18:0] sel_mask;
  logic window_open, erase_suspended, abort_pulse, start_pulse;

  always #4 clk = ~clk;

  sew_accum #(.WIN_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_erase_wr(se), .sec_idx(idx),
    .suspend_wr(su), .resume_wr(re), .other_cmd_wr(ot), .erase_done(dn),
    .sel_mask(sel_mask), .window_open(window_open),
    .erase_suspended(erase_suspended), .abort_pulse(abort_pulse),
    .start_pulse(start_pulse)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R12";

  // model: 0 idle, 1 window, 2 busy, 3 suspended
  int m_st = 0, m_rem = 0;
  logic [18:0] m_mask = '0;
  logic m_started = 1'b0, m_start = 1'b0, m_abort = 1'b0;

  function automatic logic [18:0] bit_of(input int n);
    return 19'(1) << n;
  endfunction

  task automatic model_step();
    bit valid = se && (int'(idx) <= 18);
    m_start = 1'b0;
    m_abort = 1'b0;
    if (m_st == 0) begin
      if (valid) begin m_st = 1; m_rem = W; m_mask = bit_of(int'(idx)); end
    end else if (m_st == 1) begin
      if (ot || re) begin m_st = 0; m_mask = '0; m_abort = 1'b1; m_started = 1'b0; end
      else if (su) m_st = 3;
      else if (valid) begin m_rem = W; m_mask = m_mask | bit_of(int'(idx)); end
      else if (m_rem == 1) begin m_st = 2; m_start = 1'b1; m_started = 1'b1; end
      else m_rem = m_rem - 1;
    end else if (m_st == 2) begin
      if (dn) begin m_st = 0; m_mask = '0; m_started = 1'b0; end
      else if (su) m_st = 3;
    end else begin
      if (re) begin
        m_st = 2;
        if (!m_started) begin m_start = 1'b1; m_started = 1'b1; end
      end
    end
  endtask

  task automatic cmp(input string what, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("sel_mask", sel_mask, m_mask);
    cmp("window_open", 19'(window_open), 19'(m_st == 1));
    cmp("erase_suspended", 19'(erase_suspended), 19'(m_st == 3));
    cmp("abort_pulse", 19'(abort_pulse), 19'(m_abort));
    cmp("start_pulse", 19'(start_pulse), 19'(m_start));
  endtask

  task automatic cyc(input bit a_se, input int a_idx, input bit a_su, input bit a_re,
                     input bit a_ot, input bit a_dn);
    se = a_se; idx = 5'(a_idx); su = a_su; re = a_re; ot = a_ot; dn = a_dn;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5E1A));
    // R12: reset state
    tag = "R12";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    idle(2);

    // R1: open the window on sector 3
    tag = "R1";
    cyc(1, 3, 0, 0, 0, 0);
    // R2: full window then start
    tag = "R2";
    idle(W + 2);
    tag = "R9";
    cyc(0, 0, 0, 0, 0, 1);

    // R3: write on the last window cycle is accepted
    tag = "R3";
    cyc(1, 0, 0, 0, 0, 0);
    idle(W - 1);
    cyc(1, 5, 0, 0, 0, 0);
    idle(W + 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R4: duplicate sector restarts count
    tag = "R4";
    cyc(1, 7, 0, 0, 0, 0);
    idle(5);
    cyc(1, 7, 0, 0, 0, 0);
    idle(W + 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R5: abort beats same-cycle write and suspend
    tag = "R5";
    cyc(1, 2, 0, 0, 0, 0);
    cyc(1, 4, 0, 0, 0, 0);
    cyc(1, 6, 1, 0, 1, 0);
    idle(2);
    cyc(1, 2, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    idle(1);

    // R6: suspend beats write, no start
    tag = "R6";
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 9, 1, 0, 0, 0);
    idle(W + 2);
    cyc(1, 8, 0, 0, 1, 1);
    // R7: resume starts the never-started erase
    tag = "R7";
    cyc(0, 0, 0, 1, 0, 0);
    // R8: busy ignores writes and commands, suspend/resume without new start
    tag = "R8";
    cyc(1, 11, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    // R9: done beats suspend
    tag = "R9";
    cyc(0, 0, 1, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R10: out-of-range index
    tag = "R10";
    cyc(1, 25, 0, 0, 0, 0);
    cyc(1, 19, 0, 0, 0, 0);
    cyc(1, 12, 0, 0, 0, 0);
    idle(W - 2);
    cyc(1, 31, 0, 0, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 1);

    // R11: every sector
    tag = "R11";
    for (int s = 18; s >= 0; s--) cyc(1, s, 0, 0, 0, 0);
    cmp("all sectors", sel_mask, 19'h7FFFF);
    idle(W + 1);
    cyc(0, 0, 0, 0, 0, 1);

    // random mix: collisions of R3/R5/R6/R9 events
    tag = "RANDOM R3/R5/R6/R9";
    for (int k = 0; k < 4000; k++) begin
      bit r_se = ($urandom_range(99) < 30);
      int r_ix = ($urandom_range(9) == 0) ? int'($urandom_range(31)) : int'($urandom_range(18));
      bit r_su = ($urandom_range(99) < 4);
      bit r_re = ($urandom_range(99) < 4);
      bit r_ot = ($urandom_range(99) < 3);
      bit r_dn = ($urandom_range(99) < 6);
      cyc(r_se, r_ix, r_su, r_re, r_ot, r_dn);
    end
    finish_run();
  end
endmodule